// File: doc/BRIEF.md
# Bidirectional Counter with Carry Outputs

A synchronous binary counter, WIDTH bits wide (four by default), that counts up or down modulo 2^WIDTH. One mode decoder resolves the controls in a fixed order: an asynchronous clear, then a synchronous clear, then a parallel load, then a count, then hold. A count step needs two active-low enables to be low together. The parallel enable gates only this stage. The trickle enable also gates the terminal-count output, so stages can be chained.

The terminal-count output is active low and combinational. It marks the last state in the current direction: all ones when counting up, all zeros when counting down. A second output is also active low. It is armed on the falling clock edge and released on the rising edge, so its low pulse is clean enough to clock other logic. The data outputs model a three-state bus as a value and a drive flag. Disabling the drive does not stop the counter.

To build a wider look-ahead counter, feed the first stage's terminal count to the parallel enable of every later stage. Chain each stage's terminal count into the next stage's trickle enable.

Top module: `updown_carry_counter`

## Requirements
- R1: With both enables low and no reset or load, each rising edge adds one when up_i is 1 and subtracts one when up_i is 0, modulo 2^WIDTH. Up wraps from all ones to zero, and down wraps from zero to all ones.
- R2: While rst_ni is 0, q_o is zero at once, with no clock edge needed, whatever the other inputs and clock edges do.
- R3: When srst_ni is 0 at a rising edge, q_o becomes zero after that edge, whatever load_ni, cnt_par_ni and cnt_trk_ni are.
- R4: When srst_ni is 1 and load_ni is 0 at a rising edge, q_o takes data_i after that edge, whatever the enables are.
- R5: When srst_ni and load_ni are 1 and either cnt_par_ni or cnt_trk_ni is 1, q_o keeps its value across the edge.
- R6: tc_no is 0 only when cnt_trk_ni is 0 and either q_o is all ones with up_i = 1 or q_o is zero with up_i = 0. It follows up_i and cnt_trk_ni without a clock edge.
- R7: cc_no is 1 while clk_i is 1. During a low phase it is 0 only if cnt_par_ni, cnt_trk_ni and tc_no were all 0 at the falling edge that began that phase.
- R8: q_en_o is the inverse of hiz_i. Counting goes on while hiz_i is 1, and q_o keeps showing the internal value.
- R9: Two stages joined for look-ahead carry (each stage's tc_no drives the next stage's cnt_par_ni and cnt_trk_ni) count as one 2·WIDTH-bit counter in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous clear, active low |
| srst_ni | input | 1 | Synchronous clear, active low |
| load_ni | input | 1 | Parallel load, active low |
| cnt_par_ni | input | 1 | Parallel count enable, active low |
| cnt_trk_ni | input | 1 | Trickle count enable, active low; also gates tc_no |
| up_i | input | 1 | Direction: 1 up, 0 down |
| hiz_i | input | 1 | 1 releases the data outputs |
| data_i | input | WIDTH | Value to load |
| q_o | output | WIDTH | Counter value |
| q_en_o | output | 1 | 1 when q_o drives the bus |
| tc_no | output | 1 | Terminal count, active low |
| cc_no | output | 1 | Clocked carry, active low, low-phase pulse |

## Verification
A clocked stimulus is checked on q_o two nanoseconds after the rising edge that applies it. At the same moment the bench checks tc_no against the new value, and checks that cc_no is high. cc_no is then checked two nanoseconds after the next falling edge, against the enables and terminal count present at that edge. Changes to direction and trickle enable are checked on tc_no one nanosecond later, with the count disabled so no edge can interfere. The asynchronous clear is checked one nanosecond after it is asserted in the middle of a phase.

// File: rtl/updown_carry_counter_pkg.sv
package updown_carry_counter_pkg;
  typedef enum logic [2:0] {
    MODE_HOLD  = 3'd0,
    MODE_CLEAR = 3'd1,
    MODE_LOAD  = 3'd2,
    MODE_UP    = 3'd3,
    MODE_DOWN  = 3'd4
  } cnt_mode_e;
endpackage

// File: rtl/ucc_mode_dec.sv
module ucc_mode_dec
  import updown_carry_counter_pkg::*;
(
  input  logic      srst_ni,
  input  logic      load_ni,
  input  logic      cnt_par_ni,
  input  logic      cnt_trk_ni,
  input  logic      up_i,
  output cnt_mode_e mode_o
);
  // fixed precedence: clear > load > count > hold
  always_comb begin
    if (!srst_ni)                        mode_o = MODE_CLEAR;
    else if (!load_ni)                   mode_o = MODE_LOAD;
    else if (!cnt_par_ni && !cnt_trk_ni) mode_o = up_i ? MODE_UP : MODE_DOWN;
    else                                 mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/ucc_state_reg.sv
module ucc_state_reg
  import updown_carry_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_mode_e        mode_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] q_q, q_d;

  always_comb begin
    unique case (mode_i)
      MODE_CLEAR: q_d = '0;
      MODE_LOAD:  q_d = data_i;
      MODE_UP:    q_d = q_q + ONE;
      MODE_DOWN:  q_d = q_q - ONE;
      default:    q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/ucc_tc_dec.sv
module ucc_tc_dec #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_i,
  input  logic             cnt_trk_ni,
  output logic             tc_no
);
  logic at_max, at_min;

  assign at_max = &q_i;
  assign at_min = ~|q_i;
  assign tc_no  = ~(~cnt_trk_ni & (up_i ? at_max : at_min));
endmodule

// File: rtl/ucc_carry_gate.sv
module ucc_carry_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_par_ni,
  input  logic cnt_trk_ni,
  input  logic tc_ni,
  output logic cc_no
);
  logic arm_q;

  // armed on the falling edge so decode glitches never reach cc_no
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= ~cnt_par_ni & ~cnt_trk_ni & ~tc_ni;
  end

  assign cc_no = ~(arm_q & ~clk_i);
endmodule

// File: rtl/updown_carry_counter.sv
module updown_carry_counter
  import updown_carry_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_ni,
  input  logic             load_ni,
  input  logic             cnt_par_ni,
  input  logic             cnt_trk_ni,
  input  logic             up_i,
  input  logic             hiz_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o,
  output logic             q_en_o,
  output logic             tc_no,
  output logic             cc_no
);
  cnt_mode_e        mode;
  logic [WIDTH-1:0] q;
  logic             tc_n;

  ucc_mode_dec u_mode_dec (
    .srst_ni    (srst_ni),
    .load_ni    (load_ni),
    .cnt_par_ni (cnt_par_ni),
    .cnt_trk_ni (cnt_trk_ni),
    .up_i       (up_i),
    .mode_o     (mode)
  );

  ucc_state_reg #(.WIDTH(WIDTH)) u_state_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .data_i (data_i),
    .q_o    (q)
  );

  ucc_tc_dec #(.WIDTH(WIDTH)) u_tc_dec (
    .q_i        (q),
    .up_i       (up_i),
    .cnt_trk_ni (cnt_trk_ni),
    .tc_no      (tc_n)
  );

  ucc_carry_gate u_carry_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_par_ni (cnt_par_ni),
    .cnt_trk_ni (cnt_trk_ni),
    .tc_ni      (tc_n),
    .cc_no      (cc_no)
  );

  assign q_o    = q;
  assign q_en_o = ~hiz_i;
  assign tc_no  = tc_n;
endmodule

// File: rtl/updown_carry_counter_chk.sv
module updown_carry_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             srst_ni,
  input logic             load_ni,
  input logic             cnt_par_ni,
  input logic             cnt_trk_ni,
  input logic             up_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] q_o,
  input logic             tc_no,
  input logic             cc_no
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  AST_SYNC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_ni |=> q_o == '0); // R3
  AST_LOAD_TAKES_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_ni && !load_ni |=> q_o == $past(data_i)); // R4
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_ni && load_ni && (cnt_par_ni || cnt_trk_ni) |=> $stable(q_o)); // R5
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_ni && load_ni && !cnt_par_ni && !cnt_trk_ni && up_i
    |=> q_o == $past(q_o) + ONE); // R1
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_ni && load_ni && !cnt_par_ni && !cnt_trk_ni && !up_i
    |=> q_o == $past(q_o) - ONE); // R1
  AST_TC_NEEDS_TRICKLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_trk_ni |-> tc_no); // R6
  AST_CC_HIGH_PHASE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cc_no); // R7
endmodule

bind updown_carry_counter updown_carry_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .srst_ni    (srst_ni),
  .load_ni    (load_ni),
  .cnt_par_ni (cnt_par_ni),
  .cnt_trk_ni (cnt_trk_ni),
  .up_i       (up_i),
  .data_i     (data_i),
  .q_o        (q_o),
  .tc_no      (tc_no),
  .cc_no      (cc_no)
);

// File: tb/updown_carry_counter_bench.sv
module updown_carry_counter_bench;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0, srst_n = 1'b1, load_n = 1'b1;
  logic         cep_n = 1'b1, cet_n = 1'b1, up = 1'b1, hiz = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q;
  logic         q_en, tc_n, cc_n;

  updown_carry_counter #(.WIDTH(W)) u_updown_carry_counter (
    .clk_i(clk), .rst_ni(rst_n), .srst_ni(srst_n), .load_ni(load_n),
    .cnt_par_ni(cep_n), .cnt_trk_ni(cet_n), .up_i(up), .hiz_i(hiz),
    .data_i(d), .q_o(q), .q_en_o(q_en), .tc_no(tc_n), .cc_no(cc_n)
  );

  // two-stage look-ahead cascade
  logic         c_cnt_n = 1'b1, c_up = 1'b1;
  logic [W-1:0] lo_q, hi_q;
  logic         lo_tc_n, hi_tc_n, lo_cc_n, hi_cc_n, lo_en, hi_en;

  updown_carry_counter #(.WIDTH(W)) u_lo (
    .clk_i(clk), .rst_ni(rst_n), .srst_ni(1'b1), .load_ni(1'b1),
    .cnt_par_ni(c_cnt_n), .cnt_trk_ni(c_cnt_n), .up_i(c_up), .hiz_i(1'b0),
    .data_i('0), .q_o(lo_q), .q_en_o(lo_en), .tc_no(lo_tc_n), .cc_no(lo_cc_n)
  );
  updown_carry_counter #(.WIDTH(W)) u_hi (
    .clk_i(clk), .rst_ni(rst_n), .srst_ni(1'b1), .load_ni(1'b1),
    .cnt_par_ni(lo_tc_n), .cnt_trk_ni(lo_tc_n), .up_i(c_up), .hiz_i(1'b0),
    .data_i('0), .q_o(hi_q), .q_en_o(hi_en), .tc_no(hi_tc_n), .cc_no(hi_cc_n)
  );

  int total = 0, bad = 0, mq = 0, cm = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_tc();
    return (!cet_n && ((up && mq == M-1) || (!up && mq == 0))) ? 0 : 1;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one clock: model step, check q/tc in high phase, cc in low phase
  task automatic tick(input string tag);
    @(posedge clk);
    if (!srst_n)              mq = 0;
    else if (!load_n)         mq = int'(d);
    else if (!cep_n && !cet_n) mq = up ? (mq + 1) % M : (mq + M - 1) % M;
    #2;
    chk(tag, 32'(q), 32'(mq));
    chk("R6 tc", 32'(tc_n), 32'(exp_tc()));
    chk("R7 cc high phase", 32'(cc_n), 1);
    @(negedge clk);
    #2;
    chk("R7 cc low phase", 32'(cc_n), (!cep_n && !cet_n && exp_tc() == 0) ? 0 : 1);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #12;
    chk("R2 reset q", 32'(q), 0);
    chk("R6 reset tc", 32'(tc_n), 1);
    chk("R7 reset cc", 32'(cc_n), 1);
    rst_n = 1'b1;

    // R1 up and down sweeps across wrap
    cep_n = 1'b0; cet_n = 1'b0; up = 1'b1;
    repeat (2*M + 3) tick("R1 up");
    up = 1'b0;
    repeat (2*M + 3) tick("R1 down");

    // R5 hold with either enable high
    cep_n = 1'b1; repeat (4) tick("R5 hold par");
    cep_n = 1'b0; cet_n = 1'b1; repeat (4) tick("R5 hold trk");
    cep_n = 1'b1; repeat (4) tick("R5 hold both");

    // R4 load every value under every enable pattern
    load_n = 1'b0;
    for (int v = 0; v < M; v++) begin
      d = W'(v); cep_n = v[0]; cet_n = v[1]; up = v[2];
      tick("R4 load");
    end
    load_n = 1'b1;

    // R3 sync clear beats load and count
    for (int v = 0; v < 4; v++) begin
      load_n = 1'b0; d = W'(9 + v); tick("R4 preload");
      srst_n = 1'b0; cep_n = v[0]; cet_n = v[1]; load_n = v[0];
      tick("R3 sync clear");
      srst_n = 1'b1;
    end
    load_n = 1'b1;

    // R8 outputs released, counting continues
    cep_n = 1'b0; cet_n = 1'b0; up = 1'b1; hiz = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick("R8 count while released");
      chk("R8 q_en released", 32'(q_en), 0);
    end
    hiz = 1'b0; #1;
    chk("R8 q_en driven", 32'(q_en), 1);

    // R6 direction and trickle toggles at the ends, count held
    load_n = 1'b0; d = W'(M-1); cep_n = 1'b1; tick("R4 load max");
    load_n = 1'b1; cet_n = 1'b0;
    up = 1'b1; #1; chk("R6 max up", 32'(tc_n), 0);
    up = 1'b0; #1; chk("R6 max down", 32'(tc_n), 1);
    up = 1'b1; cet_n = 1'b1; #1; chk("R6 max trk off", 32'(tc_n), 1);
    cet_n = 1'b0; #1; chk("R6 max trk on", 32'(tc_n), 0);
    @(negedge clk); #1;
    load_n = 1'b0; d = '0; tick("R4 load zero");
    load_n = 1'b1;
    up = 1'b0; #1; chk("R6 zero down", 32'(tc_n), 0);
    up = 1'b1; #1; chk("R6 zero up", 32'(tc_n), 1);
    up = 1'b0; cet_n = 1'b1; #1; chk("R6 zero trk off", 32'(tc_n), 1);
    @(negedge clk); #1;

    // R7 carry pulse at both ends; blocked when parallel enable high
    cet_n = 1'b0; cep_n = 1'b0; up = 1'b1;
    load_n = 1'b0; d = W'(M-2); tick("R4 load");
    load_n = 1'b1;
    repeat (3) tick("R7 up through max");
    up = 1'b0; repeat (3) tick("R7 down through zero");
    load_n = 1'b0; d = '0; cep_n = 1'b1; tick("R7 par blocks cc");
    load_n = 1'b1; tick("R7 par blocks cc hold");

    // R2 async clear mid-phase, held across an edge with load pending
    load_n = 1'b0; d = W'(11); tick("R4 load");
    #1; rst_n = 1'b0; #1;
    chk("R2 async clear", 32'(q), 0);
    d = W'(5);
    @(posedge clk); #1;
    chk("R2 held over edge", 32'(q), 0);
    @(negedge clk); #1;
    rst_n = 1'b1; mq = 0; cm = 0; load_n = 1'b1;

    // R9 cascade as 2W-bit counter, both directions
    c_cnt_n = 1'b0; c_up = 1'b1;
    for (int i = 0; i < M*M + 20; i++) begin
      @(posedge clk); cm = (cm + 1) % (M*M);
      #2; chk("R9 cascade up", 32'({hi_q, lo_q}), 32'(cm));
    end
    @(negedge clk); c_up = 1'b0;
    for (int i = 0; i < M*M + 20; i++) begin
      @(posedge clk); cm = (cm + M*M - 1) % (M*M);
      #2; chk("R9 cascade down", 32'({hi_q, lo_q}), 32'(cm));
    end
    finish_run();
  end
endmodule